// File: doc/BRIEF.md
# Serial Transmitter Channel with Clear-to-Send Pause

This block is one transmit channel of an asynchronous serial port. A host writes a byte with a one-cycle strobe into a single holding slot. From there the byte moves into a shift register and goes out on the serial line as a frame: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Bit timing comes from an external enable pulse, `bit_tick`. In 16x mode each bit lasts sixteen ticks. In 1x mode each bit lasts one tick.

The host sees two status flags. Ready (`tx_rdy`) means a byte may be written. Empty (`tx_emt`) means nothing is held and nothing is on the line. Separate command strobes enable the channel, disable it, start a break and end a break. Optional clear-to-send gating holds back new frames while the active-low `cts_n` input is high. A frame already on the line is never cut by this gating. An optional general output pin can show the empty condition to the far end.

Disabling the channel very soon after a byte is loaded throws that byte away. This applies while the byte still waits, or while fewer than three sixteenths of its start bit have passed in 16x mode. In 1x mode it applies until its one-tick start bit has completed. Disabling later lets the frame finish.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd` is 1, `tx_rdy` is 0 and `tx_emt` is 1. In the cycle after an `en_cmd` pulse, with the slot empty and no break requested, `tx_rdy` is 1.
- R2: A frame is sent in this order: a start bit of 0, then `len_code`+5 data bits with the least significant bit first (`len_code` 0..3 gives 5..8 bits), then a parity bit when `par_en`=1, then one stop bit of 1 (two when `two_stop`=1). The parity bit depends on `par_kind`. Code 0 is even: the ones in the data bits plus the parity bit come to an even count. Code 1 is odd. Code 2 forces the bit to 0 and code 3 forces it to 1.
- R3: With `x1_mode`=0 every bit lasts 16 `bit_tick` pulses. With `x1_mode`=1 every bit lasts one pulse. When the channel is idle and allowed to send, the start bit begins in the clock cycle after the write is taken.
- R4: `tx_rdy` falls when a write is taken and rises in the cycle after the tick that ends that frame's start bit. A write made while `tx_rdy` is 0 is ignored.
- R5: `tx_emt` is 1 exactly when the slot is empty and the line is idle (no frame, no break). `empty_n` is 0 when `empty_pin_en`=1 and `tx_emt`=1; otherwise it is 1.
- R6: With `cts_gate`=1 and `cts_n`=1 no new start bit begins. A frame already started runs to its last stop bit. A held byte starts in the cycle after `cts_n` returns to 0.
- R7: With `cts_gate`=0, `cts_n` has no effect on sending.
- R8: A `dis_cmd` pulse discards the held byte if that byte has not started. It also discards a byte whose start bit has run fewer than 3 ticks in 16x mode, or has not yet completed in 1x mode, counting only ticks before the command's cycle. `txd` returns to 1 in the next cycle. A later `dis_cmd` lets the frame finish.
- R9: While the channel is disabled, `tx_rdy` is 0, writes are ignored and no new frame begins.
- R10: A `brk_start` pulse while enabled holds `txd` at 0 once the line is idle. Writes during a break are ignored. A `brk_stop` pulse ends the break with one stop-bit time of 1. The next write is then sent normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | Bit-rate enable pulse |
| x1_mode | input | 1 | 1: one tick per bit; 0: sixteen ticks per bit |
| en_cmd | input | 1 | Enable command pulse |
| dis_cmd | input | 1 | Disable command pulse |
| brk_start | input | 1 | Start-break command pulse |
| brk_stop | input | 1 | Stop-break command pulse |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| len_code | input | 2 | Data length, value+5 bits |
| par_en | input | 1 | Parity bit present |
| par_kind | input | 2 | 0 even, 1 odd, 2 forced 0, 3 forced 1 |
| two_stop | input | 1 | Two stop bits |
| cts_gate | input | 1 | Enable clear-to-send pausing |
| cts_n | input | 1 | Clear to send, active low |
| empty_pin_en | input | 1 | Drive empty flag onto `empty_n` |
| txd | output | 1 | Serial data out |
| tx_rdy | output | 1 | Holding slot free |
| tx_emt | output | 1 | Slot empty and line idle |
| empty_n | output | 1 | Active-low empty indication pin |

## Verification
Two events can land on the same clock edge: the disable command and the bit tick that would end, or advance, a start bit. The disable must win in 1x mode and before the third tick in 16x mode. The bench places `dis_cmd` on the very edge that carries the ending tick in 1x mode. In 16x mode it places the command at the second and at the third counted tick. It then judges by whether the line returns high at once with the empty flag set, or whether the whole frame decodes correctly afterwards. A second overlap is a clear-to-send change during a frame while a byte is held. There the bench expects the frame in progress to finish whole and the held byte to wait.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;
  localparam int WORD_W  = 8;
  localparam int MIN_LEN = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
  } tx_state_e;

  // index of the last data bit for a length code
  function automatic logic [2:0] last_data_idx(input logic [1:0] lc);
    return 3'(MIN_LEN - 1) + 3'(lc);
  endfunction

  // parity bit over the active data bits
  function automatic logic parity_bit(input logic [WORD_W-1:0] w,
                                      input logic [1:0] lc,
                                      input logic [1:0] kind);
    logic [WORD_W-1:0] m;
    logic x;
    m = {WORD_W{1'b1}} >> (2'd3 - lc);
    x = ^(w & m);
    case (kind)
      2'd0: return x;
      2'd1: return ~x;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/sertx_pace.sv
`timescale 1ns/1ps
module sertx_pace #(
  parameter int SUB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             x1,
  input  logic             restart,
  output logic             bit_end,
  output logic [SUB_W-1:0] ticks_in_bit
);
  logic [SUB_W-1:0] sub;

  assign bit_end      = tick & (x1 | (&sub));
  assign ticks_in_bit = sub;

  always_ff @(posedge clk) begin
    if (!rst_n)                sub <= '0;
    else if (restart | bit_end) sub <= '0;
    else if (tick)             sub <= sub + 1'b1;
  end

  // R3
  tick_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && !bit_end) |=> (ticks_in_bit == $past(ticks_in_bit) + 1'b1));
endmodule

// File: rtl/sertx_hold.sv
`timescale 1ns/1ps
module sertx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         clear,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (load) begin
      full <= 1'b1;
      data <= load_data;
    end else if (clear) begin
      full <= 1'b0;
    end
  end

  // R4
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full);
endmodule

// File: rtl/sertx_frame.sv
`timescale 1ns/1ps
module sertx_frame import sertx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_end,
  input  logic              go_char,
  input  logic              go_brk,
  input  logic              end_brk,
  input  logic              abort,
  input  logic [WORD_W-1:0] load_word,
  input  logic [1:0]        len_code,
  input  logic              par_en,
  input  logic [1:0]        par_kind,
  input  logic              two_stop,
  output tx_state_e         st,
  output logic              txd,
  output logic              restart,
  output logic              start_done
);
  logic [WORD_W-1:0] shreg;
  logic [2:0]        idx;
  logic              pbit;
  logic              stop2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      shreg <= '0;
      idx   <= '0;
      pbit  <= 1'b0;
      stop2 <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (go_char) begin
            st    <= ST_START;
            shreg <= load_word;
            pbit  <= parity_bit(load_word, len_code, par_kind);
          end else if (go_brk) begin
            st <= ST_BRK;
          end
        end
        ST_START: begin
          if (abort) st <= ST_IDLE;
          else if (bit_end) begin
            st  <= ST_DATA;
            idx <= '0;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            shreg <= shreg >> 1;
            if (idx == last_data_idx(len_code)) begin
              st    <= par_en ? ST_PAR : ST_STOP;
              stop2 <= two_stop;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            st    <= ST_STOP;
            stop2 <= two_stop;
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            if (stop2) stop2 <= 1'b0;
            else       st    <= ST_IDLE;
          end
        end
        ST_BRK: begin
          if (end_brk) begin
            st    <= ST_STOP;
            stop2 <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      ST_PAR:   txd = pbit;
      ST_BRK:   txd = 1'b0;
      default:  txd = 1'b1;
    endcase
  end

  assign restart    = ((st == ST_IDLE)  & (go_char | go_brk)) |
                      ((st == ST_START) & abort) |
                      ((st == ST_BRK)   & end_brk);
  assign start_done = (st == ST_START) & bit_end & ~abort;

  // R10
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BRK && !end_brk) |=> (st == ST_BRK));
endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
module sertx_top import sertx_pkg::*; #(
  parameter int SUB_W        = 4,
  parameter int COMMIT_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              x1_mode,
  input  logic              en_cmd,
  input  logic              dis_cmd,
  input  logic              brk_start,
  input  logic              brk_stop,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        len_code,
  input  logic              par_en,
  input  logic [1:0]        par_kind,
  input  logic              two_stop,
  input  logic              cts_gate,
  input  logic              cts_n,
  input  logic              empty_pin_en,
  output logic              txd,
  output logic              tx_rdy,
  output logic              tx_emt,
  output logic              empty_n
);
  localparam logic [SUB_W-1:0] COMMIT_AT = SUB_W'(COMMIT_TICKS);

  logic              enabled, brk_req;
  tx_state_e         st;
  logic              hold_full;
  logic [WORD_W-1:0] hold_word;
  logic              bit_end, restart, start_done;
  logic [SUB_W-1:0]  ticks_in_bit;

  // named internal events
  logic committed, drop, abort, cts_ok, go_char, go_brk, accept;

  assign committed = (st == ST_START) & ~x1_mode & (ticks_in_bit >= COMMIT_AT);
  assign drop      = dis_cmd & hold_full & ~committed;
  assign abort     = drop & (st == ST_START);
  assign cts_ok    = ~cts_gate | ~cts_n;
  assign go_char   = enabled & cts_ok & hold_full & ~dis_cmd;
  assign go_brk    = brk_req & ~brk_stop;
  assign accept    = wr_stb & enabled & ~dis_cmd & ~hold_full & ~brk_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      brk_req <= 1'b0;
    end else begin
      if (dis_cmd)     enabled <= 1'b0;
      else if (en_cmd) enabled <= 1'b1;
      if (brk_stop)                  brk_req <= 1'b0;
      else if (brk_start && enabled) brk_req <= 1'b1;
    end
  end

  sertx_pace #(.SUB_W(SUB_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .x1(x1_mode),
    .restart(restart), .bit_end(bit_end), .ticks_in_bit(ticks_in_bit)
  );

  sertx_hold #(.W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(wr_data),
    .clear(start_done | drop), .full(hold_full), .data(hold_word)
  );

  sertx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .bit_end(bit_end), .go_char(go_char),
    .go_brk(go_brk), .end_brk(brk_stop), .abort(abort),
    .load_word(hold_word), .len_code(len_code), .par_en(par_en),
    .par_kind(par_kind), .two_stop(two_stop), .st(st), .txd(txd),
    .restart(restart), .start_done(start_done)
  );

  assign tx_rdy  = enabled & ~hold_full & ~brk_req;
  assign tx_emt  = ~hold_full & (st == ST_IDLE);
  assign empty_n = ~(empty_pin_en & tx_emt);

  // R6
  cts_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cts_gate && cts_n) |=> (st != ST_START));

  // R8
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (st == ST_IDLE && !hold_full));

  // R5
  emt_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_emt |-> txd);

  // R4
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy) |-> $past(start_done || en_cmd || brk_stop));

  // R10
  brk_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !brk_stop && st == ST_IDLE && !go_char) |=> (st == ST_BRK));
endmodule

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic x1_mode = 1'b0;
  logic en_cmd = 1'b0, dis_cmd = 1'b0, brk_start = 1'b0, brk_stop = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] len_code = 2'd3;
  logic par_en = 1'b0;
  logic [1:0] par_kind = 2'd0;
  logic two_stop = 1'b0;
  logic cts_gate = 1'b0, cts_n = 1'b0, empty_pin_en = 1'b0;
  logic txd, tx_rdy, tx_emt, empty_n;

  int nchk = 0, nerr = 0;
  int tdiv = 2, tcnt = 0, ticks_seen = 0, base = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sertx_top u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .x1_mode(x1_mode),
    .en_cmd(en_cmd), .dis_cmd(dis_cmd), .brk_start(brk_start), .brk_stop(brk_stop),
    .wr_stb(wr_stb), .wr_data(wr_data), .len_code(len_code), .par_en(par_en),
    .par_kind(par_kind), .two_stop(two_stop), .cts_gate(cts_gate), .cts_n(cts_n),
    .empty_pin_en(empty_pin_en), .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt),
    .empty_n(empty_n)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= 0; bit_tick <= 1'b0;
    end else begin
      tcnt <= (tcnt >= tdiv - 1) ? 0 : tcnt + 1;
      bit_tick <= (tcnt == tdiv - 1);
      if (bit_tick) ticks_seen <= ticks_seen + 1;
    end
  end

  task automatic report;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !finished) begin
      nerr++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      report();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // 0 enable, 1 disable, 2 break start, 3 break stop
  task automatic cmd(input int which);
    case (which)
      0: en_cmd = 1'b1;
      1: dis_cmd = 1'b1;
      2: brk_start = 1'b1;
      default: brk_stop = 1'b1;
    endcase
    @(negedge clk);
    en_cmd = 1'b0; dis_cmd = 1'b0; brk_start = 1'b0; brk_stop = 1'b0;
  endtask

  task automatic write(input logic [7:0] d);
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic find_start(output int lat);
    lat = 0;
    while (txd !== 1'b0 && lat < 30000) begin
      @(negedge clk);
      lat++;
    end
    base = ticks_seen;
  endtask

  task automatic wait_since(input int n);
    while (ticks_seen - base < n) @(negedge clk);
  endtask

  task automatic hold_level(input int n, input logic lvl, input string req);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (txd !== lvl) bad = 1;
    end
    chk(req, bad, 0);
  endtask

  function automatic int build(input logic [7:0] d, input int lc, input int pk,
                               input bit ts, output logic [15:0] f);
    int n = lc + 5;
    int p = 1;
    int ones = 0;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      f[p] = d[i];
      ones += d[i];
      p++;
    end
    if (pk < 4) begin
      case (pk)
        0: f[p] = 1'((ones % 2) == 1);
        1: f[p] = 1'((ones % 2) == 0);
        2: f[p] = 1'b0;
        default: f[p] = 1'b1;
      endcase
      p++;
    end
    p += ts ? 2 : 1;
    return p;
  endfunction

  // samples bits k0..nb-1 of the frame that started at base and compares them
  task automatic sample_cmp(input string req, input logic [7:0] d, input int lc,
                            input int pk, input bit ts, input int k0, input bit chk_rdy);
    logic [15:0] exp_f, got;
    int nb, per, off;
    int mism = 0;
    nb = build(d, lc, pk, ts, exp_f);
    per = x1_mode ? 1 : 16;
    off = x1_mode ? 0 : 8;
    got = '1;
    for (int k = k0; k < nb; k++) begin
      wait_since(k * per + off);
      got[k] = txd;
      if (got[k] !== exp_f[k]) mism++;
      if (chk_rdy && k == 0) chk("R4 rdy low in start bit", int'(tx_rdy), 0);
      if (chk_rdy && k == 1) chk("R4 rdy high after start bit", int'(tx_rdy), 1);
    end
    if (mism != 0)
      $display("FAIL %s frame act=%h exp=%h", req, got, exp_f);
    nchk++;
    if (mism != 0) nerr++;
    wait_since(nb * per);
    chk("R5 empty at frame end", int'(tx_emt), 1);
  endtask

  task automatic send(input string req, input logic [7:0] d, input int lc,
                      input int pk, input bit ts);
    int lat;
    len_code = 2'(lc);
    par_en = (pk < 4);
    par_kind = 2'(pk);
    two_stop = ts;
    write(d);
    find_start(lat);
    chk("R3 start latency", lat, 1);
    sample_cmp(req, d, lc, pk, ts, 0, 1'b1);
  endtask

  initial begin
    int lat;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txd idle", int'(txd), 1);
    chk("R1 rdy at reset", int'(tx_rdy), 0);
    chk("R5 emt at reset", int'(tx_emt), 1);
    chk("R5 pin off", int'(empty_n), 1);
    cmd(0);
    chk("R1 rdy after enable", int'(tx_rdy), 1);

    // R2 R3 sweep in 16x mode
    for (int lc = 0; lc < 4; lc++)
      for (int pk = 0; pk < 5; pk++)
        for (int ts = 0; ts < 2; ts++)
          send("R2 16x frame", 8'(8'hA5 ^ (lc * 37 + pk * 11 + ts * 3)), lc, pk, 1'(ts));

    // R4 write while slot full is ignored
    len_code = 2'd3; par_en = 1'b0; two_stop = 1'b0;
    write(8'h3C);
    write(8'hC3);
    find_start(lat);
    sample_cmp("R4 first kept", 8'h3C, 3, 4, 0, 0, 1'b0);
    hold_level(600, 1'b1, "R4 second dropped");

    // R6 pause at character boundary
    cts_gate = 1'b1;
    write(8'hFF);
    find_start(lat);
    wait_since(20);
    cts_n = 1'b1;
    write(8'h5A);
    wait_since(10 * 16);
    hold_level(800, 1'b1, "R6 no start while cts high");
    chk("R6 byte still held", int'(tx_emt), 0);
    cts_n = 1'b0;
    find_start(lat);
    chk("R6 resume latency", lat, 1);
    sample_cmp("R6 held frame", 8'h5A, 3, 4, 0, 0, 1'b0);
    cts_n = 1'b1;
    write(8'h81);
    hold_level(400, 1'b1, "R6 blocked from idle");
    cts_n = 1'b0;
    find_start(lat);
    chk("R6 idle resume latency", lat, 1);
    sample_cmp("R6 frame after release", 8'h81, 3, 4, 0, 0, 1'b0);

    // R7 gating off, plus empty pin
    cts_gate = 1'b0; cts_n = 1'b1; empty_pin_en = 1'b1;
    @(negedge clk);
    chk("R5 pin low when empty", int'(empty_n), 0);
    write(8'h96);
    find_start(lat);
    chk("R7 cts ignored latency", lat, 1);
    chk("R5 pin high while busy", int'(empty_n), 1);
    sample_cmp("R7 frame with cts high", 8'h96, 3, 4, 0, 0, 1'b0);
    chk("R5 pin low after frame", int'(empty_n), 0);
    cts_n = 1'b0; empty_pin_en = 1'b0;

    // R8 disable window in 16x mode
    write(8'h55);
    find_start(lat);
    wait_since(2);
    cmd(1);
    chk("R8 line high after early disable", int'(txd), 1);
    chk("R8 empty after early disable", int'(tx_emt), 1);
    chk("R9 rdy low when disabled", int'(tx_rdy), 0);
    hold_level(600, 1'b1, "R8 dropped byte not sent");
    cmd(0);
    write(8'h55);
    find_start(lat);
    wait_since(3);
    cmd(1);
    sample_cmp("R8 late disable frame completes", 8'h55, 3, 4, 0, 0, 1'b0);
    write(8'h11);
    chk("R9 rdy low when disabled", int'(tx_rdy), 0);
    hold_level(400, 1'b1, "R9 write while disabled");
    cmd(0);
    hold_level(100, 1'b1, "R9 ignored write not stored");
    chk("R9 empty after re-enable", int'(tx_emt), 1);
    cts_gate = 1'b1; cts_n = 1'b1;
    write(8'h42);
    cmd(1);
    cmd(0);
    cts_n = 1'b0;
    hold_level(400, 1'b1, "R8 waiting byte dropped");
    cts_gate = 1'b0;

    // R3 1x mode frames
    x1_mode = 1'b1; tdiv = 3;
    repeat (4) @(negedge clk);
    for (int pk = 0; pk < 5; pk++)
      send("R3 1x frame", 8'(8'h3B + pk * 29), 3, pk, 1'b1);

    // R8 disable on the same edge as the start-ending tick in 1x mode
    len_code = 2'd3; par_en = 1'b0; two_stop = 1'b0;
    write(8'hA7);
    find_start(lat);
    while (bit_tick !== 1'b1) @(negedge clk);
    cmd(1);
    chk("R8 1x coincident drop line", int'(txd), 1);
    chk("R8 1x coincident drop empty", int'(tx_emt), 1);
    hold_level(100, 1'b1, "R8 1x dropped byte not sent");
    cmd(0);
    write(8'hA7);
    find_start(lat);
    wait_since(1);
    cmd(1);
    sample_cmp("R8 1x late disable completes", 8'hA7, 3, 4, 0, 1, 1'b0);

    // R10 break
    x1_mode = 1'b0; tdiv = 2;
    cmd(0);
    cmd(2);
    @(negedge clk);
    chk("R10 line low in break", int'(txd), 0);
    chk("R10 rdy low in break", int'(tx_rdy), 0);
    write(8'hE1);
    hold_level(300, 1'b0, "R10 break held");
    cmd(3);
    chk("R10 mark after break", int'(txd), 1);
    hold_level(300, 1'b1, "R10 write during break not sent");
    chk("R10 empty after break", int'(tx_emt), 1);
    chk("R10 rdy after break", int'(tx_rdy), 1);
    send("R10 frame after break", 8'h3E, 3, 4, 1'b0);

    report();
  end
endmodule